// File: doc/BRIEF.md
# Bit-Serial CRC-8 Generator and Checker

This block computes the 8-bit cyclic redundancy check used on single-wire device buses, one bit at a time. Each cycle in which the shift strobe is high, one data bit is folded into an 8-bit state register. The generator polynomial is x^8 + x^5 + x^4 + 1, and the register uses the right-shifting (reflected) form of that polynomial.

The block has two uses. As a generator, the caller clears the state and then shifts in a 56-bit device identity. The register then holds the check byte for that identity. As a checker, the caller shifts in the received data followed by the received check byte, and reads the zero flag. The flag is high when the data and check byte agree. Bytes are presented least significant bit first. Framing and bus timing belong to the caller.

Top module: `serial_crc8`

## Requirements
- R1: While `rst_n` is low, `crc_out` is 0x00 and `crc_zero` is 1. The first cycle after release still shows 0x00.
- R2: When `clr` is high at a clock edge, `crc_out` is 0x00 after that edge, even if `bit_en` is also high.
- R3: When `bit_en` is high and `clr` is low, the update is as follows. Let f = `bit_in` XOR old bit 0. The new bit 7 is f. The new bits 3 and 2 are old bits 4 and 3, each XOR f. Every other new bit i (i = 6, 5, 4, 1, 0) is old bit i+1.
- R4: When `bit_en` and `clr` are both low, `crc_out` keeps its value.
- R5: `crc_zero` is 1 exactly when `crc_out` is 0x00, in the same cycle.
- R6: Start from a cleared state. Shift in the bytes 0x02, 0x1C, 0xB8, 0x01, 0x00, 0x00, 0x00, each least significant bit first. `crc_out` then equals 0xA2.
- R7: Take any data stream and its resulting `crc_out` value. Shift that value in after the data, least significant bit first. `crc_out` then returns to 0x00 and `crc_zero` goes high.
- R8: Idle cycles between strobes do not change the result. A bit stream fed with gaps gives the same `crc_out` as the same stream fed on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of the state, takes priority over the strobe |
| bit_en | input | 1 | Shift strobe, one data bit consumed per high cycle |
| bit_in | input | 1 | Serial data bit |
| crc_out | output | 8 | Current CRC state |
| crc_zero | output | 1 | High when the state is all zeros |

## Verification
The assertions check four things on every cycle: the clear priority, the hold when idle, the match between the zero flag and the state, and the feedback path. For the feedback path they check that bit 7 takes the feedback and that the plain shift positions move down by one. Whole-message properties need complete bit streams, so only the bench scenarios can show them. These are the known identity giving 0xA2, the zero residue after the check byte is appended, and the result not depending on idle gaps. The bench also compares the state against its own bitwise model during long random runs that mix strobes, idle cycles and clears.

// File: rtl/crc8_pkg.sv
package crc8_pkg;
  localparam int          CRC8_W        = 8;
  localparam logic [7:0]  CRC8_POLY_REV = 8'h8C;

  // Feedback term of one serial step: incoming bit against the bit leaving the register.
  function automatic logic crc8_feedback(input logic lsb, input logic din);
    return lsb ^ din;
  endfunction
endpackage

// File: rtl/crc8_next_logic.sv
module crc8_next_logic #(
  parameter int               WIDTH = 8,
  parameter logic [WIDTH-1:0] POLY  = 8'h8C
) (
  input  logic [WIDTH-1:0] cur_state,
  input  logic             din,
  output logic             fb,
  output logic [WIDTH-1:0] nxt_state
);
  import crc8_pkg::*;

  assign fb = crc8_feedback(cur_state[0], din);

  for (genvar i = 0; i < WIDTH; i++) begin : g_tap
    if (i == WIDTH - 1) begin : g_top
      assign nxt_state[i] = fb & POLY[i];
    end else begin : g_mid
      assign nxt_state[i] = cur_state[i+1] ^ (fb & POLY[i]);
    end
  end
endmodule

// File: rtl/crc8_state_reg.sv
module crc8_state_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (clr)   q <= '0;
    else if (load)  q <= d;
  end
endmodule

// File: rtl/crc8_zero_detect.sv
module crc8_zero_detect #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] value,
  output logic             is_zero
);
  assign is_zero = ~|value;
endmodule

// File: rtl/serial_crc8.sv
module serial_crc8 #(
  parameter int               WIDTH = crc8_pkg::CRC8_W,
  parameter logic [WIDTH-1:0] POLY  = crc8_pkg::CRC8_POLY_REV
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             bit_en,
  input  logic             bit_in,
  output logic [WIDTH-1:0] crc_out,
  output logic             crc_zero
);
  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] state_d;
  logic             fb_bit;

  crc8_next_logic #(.WIDTH(WIDTH), .POLY(POLY)) u_next (
    .cur_state (state_q),
    .din       (bit_in),
    .fb        (fb_bit),
    .nxt_state (state_d)
  );

  crc8_state_reg #(.WIDTH(WIDTH)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .load  (bit_en),
    .d     (state_d),
    .q     (state_q)
  );

  crc8_zero_detect #(.WIDTH(WIDTH)) u_zero (
    .value   (state_q),
    .is_zero (crc_zero)
  );

  assign crc_out = state_q;
endmodule

// File: rtl/serial_crc8_checks.sv
module serial_crc8_checks #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic             bit_en,
  input logic             bit_in,
  input logic [WIDTH-1:0] crc_out,
  input logic             crc_zero,
  input logic             fb_bit
);
  AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (crc_out == '0)); // R1

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (crc_out == '0)); // R2

  AST_FEEDBACK_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !clr) |=> (crc_out[WIDTH-1] == $past(bit_in ^ crc_out[0]))); // R3

  AST_LOW_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !clr) |=> (crc_out[1:0] == $past(crc_out[2:1]))); // R3

  AST_FB_WIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !clr) |=> (crc_out[WIDTH-1] == $past(fb_bit))); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_en && !clr) |=> $stable(crc_out)); // R4

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    crc_zero == ($countones(crc_out) == 0)); // R5
endmodule

bind serial_crc8 serial_crc8_checks #(.WIDTH(WIDTH)) u_checks (.*);

// File: tb/serial_crc8_test.sv
module serial_crc8_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr = 1'b0;
  logic       bit_en = 1'b0;
  logic       bit_in = 1'b0;
  logic [7:0] crc_out;
  logic       crc_zero;

  int unsigned checks = 0;
  int unsigned fails  = 0;
  int unsigned cycles = 0;
  logic [7:0]  model  = 8'h00;
  logic        done   = 1'b0;

  always #2.5 clk = ~clk;

  serial_crc8 uut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .bit_en(bit_en),
    .bit_in(bit_in), .crc_out(crc_out), .crc_zero(crc_zero)
  );

  // Bitwise restatement of one serial step in polynomial-tap terms.
  function automatic logic [7:0] ref_step(input logic [7:0] c, input logic d);
    logic       m;
    logic [7:0] n;
    m    = c[0] ^ d;
    n[7] = m;
    n[6] = c[7];
    n[5] = c[6];
    n[4] = c[5];
    n[3] = c[4] ^ m;
    n[2] = c[3] ^ m;
    n[1] = c[2];
    n[0] = c[1];
    return n;
  endfunction

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // One strobed bit, optional idle cycles after it; checked at the following negedge.
  task automatic push_bit(input logic b, input int gap);
    @(negedge clk);
    bit_en = 1'b1; bit_in = b;
    @(negedge clk);
    bit_en = 1'b0;
    model = ref_step(model, b);
    for (int g = 0; g < gap; g++) @(negedge clk);
  endtask

  task automatic push_byte(input logic [7:0] v, input int gap);
    for (int k = 0; k < 8; k++) push_bit(v[k], gap);
  endtask

  task automatic do_clear();
    @(negedge clk);
    clr = 1'b1; bit_en = 1'b1; bit_in = 1'b1;
    @(negedge clk);
    clr = 1'b0; bit_en = 1'b0;
    model = 8'h00;
  endtask

  initial begin : watchdog
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cycles);
      report();
    end
  end

  initial begin : stim
    logic [7:0] id_bytes [7];
    logic [7:0] snap;
    logic [7:0] gapped;
    void'($urandom(32'd20240611));
    id_bytes = '{8'h02, 8'h1C, 8'hB8, 8'h01, 8'h00, 8'h00, 8'h00};

    // R1: reset state
    #1;
    check("R1 reset value", {crc_zero, crc_out}, {1'b1, 8'h00});
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {crc_zero, crc_out}, {1'b1, 8'h00});

    // R6: known identity yields 0xA2
    for (int b = 0; b < 7; b++) push_byte(id_bytes[b], 0);
    check("R6 identity crc", {1'b0, crc_out}, {1'b0, 8'hA2});
    check("R6 model agrees", {1'b0, model}, {1'b0, 8'hA2});

    // R7: append check byte, residue zero
    snap = crc_out;
    push_byte(snap, 0);
    check("R7 residue", {crc_zero, crc_out}, {1'b1, 8'h00});

    // R2: clear with strobe also high
    push_byte(8'h5A, 0);
    check("R3 after byte", {1'b0, crc_out}, {1'b0, model});
    do_clear();
    check("R2 clear priority", {crc_zero, crc_out}, {1'b1, 8'h00});

    // R8: same identity with idle gaps
    for (int b = 0; b < 7; b++) push_byte(id_bytes[b], 2);
    gapped = crc_out;
    check("R8 gapped stream", {1'b0, gapped}, {1'b0, 8'hA2});

    // R4: idle cycles hold
    repeat (5) @(negedge clk);
    check("R4 idle hold", {1'b0, crc_out}, {1'b0, 8'hA2});

    // R7 with random messages
    for (int t = 0; t < 20; t++) begin
      int unsigned nbytes;
      do_clear();
      nbytes = 1 + ($urandom % 9);
      for (int b = 0; b < int'(nbytes); b++) push_byte(8'($urandom), 0);
      check("R3 random message", {1'b0, crc_out}, {1'b0, model});
      snap = crc_out;
      push_byte(snap, int'($urandom % 2));
      check("R7 random residue", {crc_zero, crc_out}, {1'b1, 8'h00});
    end

    // Random per-cycle mix of strobe, idle and clear
    for (int n = 0; n < 3000; n++) begin
      logic r_en, r_clr, r_bit;
      @(negedge clk);
      r_en  = ($urandom % 3) != 0;
      r_clr = ($urandom % 40) == 0;
      r_bit = 1'($urandom);
      bit_en = r_en; clr = r_clr; bit_in = r_bit;
      if (r_clr)     model = 8'h00;
      else if (r_en) model = ref_step(model, r_bit);
      @(posedge clk);
      #1;
      if (r_clr)      check("R2 random clear", {1'b0, crc_out}, {1'b0, model});
      else if (r_en)  check("R3 random step", {1'b0, crc_out}, {1'b0, model});
      else            check("R4 random idle", {1'b0, crc_out}, {1'b0, model});
      check("R5 zero flag", {8'h00, crc_zero}, {8'h00, model == 8'h00});
    end
    @(negedge clk);
    bit_en = 1'b0; clr = 1'b0;

    done = 1'b1;
    report();
  end
endmodule